// File: doc/BRIEF.md
# Sync-Tip Genlock Nibble Inserter

This block drives the 8-bit digitized video output bus. On every pixel tick (a clock-enable pulse at the pixel rate) it normally registers the incoming video sample byte onto the bus and raises a load strobe for one clock. While the horizontal sync-tip window is open, it replaces the sample with a genlock packet. The packet is sent one 4-bit nibble per pixel tick on the low four bus bits, and the upper bits are held at zero. The packet carries the subcarrier frequency word, the subcarrier phase word and a field identifier nibble.

The packet words come from the subcarrier tracking loop while video is present. When the video-present flag is low, the block sends built-in default frequency and phase words instead. These defaults are chosen by a format-select input. Packet transmission therefore never stops. The source choice is made again at the start of every sync tip, so tracked values return on the first line after video is restored, well inside two frames.

Top module: `sync_tip_inserter`

## Requirements
- R1: While reset is asserted, `vout` is 0x00 and `vout_ld` is 0.
- R2: On a pixel tick (`px_en` high at a rising clock edge) that carries no nibble, `vout` shows the `smp_in` byte of that tick from the next clock on. `vout_ld` is high for exactly the clock that follows each pixel tick.
- R3: The first tick with `tip_win` high after a tick with it low starts a 13-nibble packet. The nibbles go out on consecutive ticks in this order: the 32-bit frequency word from bits 31..28 down to bits 3..0, then the 16-bit phase word from bits 15..12 down to bits 3..0, then the 4-bit field identifier.
- R4: While a packet nibble is on the bus, `vout[7:4]` is 0 and `vout[3:0]` is the nibble.
- R5: The packet words are captured on the first tick of the sync tip. Changes to the tracked words or to `vid_ok` during the rest of the packet do not alter the nibbles sent.
- R6: If `tip_win` goes low before all 13 nibbles are sent, the rest are dropped and the bus returns to samples. The next sync tip starts again with the first frequency nibble.
- R7: Once all 13 nibbles are sent, any further ticks inside the same sync tip pass the sample byte.
- R8: If `vid_ok` is low on the first tick of the sync tip, the packet uses the defaults for `fmt_sel`, with a field identifier of 0. The defaults by `fmt_sel` value as frequency/phase are: 0 → 0x21F07C1F/0x0000, 1 → 0x2A098ACB/0x8000, 2 → 0x21F69446/0x4000, 3 → 0x21E6EFE3/0xC000.
- R9: If `vid_ok` is high on the first tick of the sync tip, the packet uses `trk_freq`, `trk_phase` and `trk_fid`. Tracked values therefore reappear on the first sync tip after video returns.
- R10: A clock with `px_en` low leaves `vout` unchanged, keeps `vout_ld` low on the next clock and does not advance the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| px_en | input | 1 | Pixel tick enable |
| smp_in | input | 8 | Video sample byte |
| tip_win | input | 1 | Horizontal sync-tip window |
| vid_ok | input | 1 | Input video present |
| fmt_sel | input | 2 | Format select for default words |
| trk_freq | input | 32 | Tracked subcarrier frequency word |
| trk_phase | input | 16 | Tracked subcarrier phase word |
| trk_fid | input | 4 | Field identifier nibble |
| vout | output | 8 | Output video bus |
| vout_ld | output | 1 | Load strobe for `vout` |

## Verification
The hardest case to reach is a packet that is partly sent, paused by pixel-enable gaps, and then cut short by the sync tip closing. The tracked words also change after capture, and the next line must restart cleanly. The bench reaches this with directed lines of chosen length. It holds `px_en` low for several clocks in the middle of a packet, closes the window after two nibbles, and opens a fresh line whose words are changed after the first tick. It also switches `vid_ok` and `fmt_sel` between lines to move from default words back to tracked ones.

// File: rtl/stn_pkg.sv
package stn_pkg;
    localparam int BUS_W  = 8;
    localparam int NIB_W  = 4;
    localparam int FREQ_W = 32;
    localparam int PH_W   = 16;
    localparam int FID_W  = 4;
    localparam int FMT_N  = 4;
    localparam int FMT_W  = 2;

    // entry i sits at bits [i*W +: W]
    localparam logic [FMT_N*FREQ_W-1:0] DEF_FREQ_TBL =
        {32'h21E6EFE3, 32'h21F69446, 32'h2A098ACB, 32'h21F07C1F};
    localparam logic [FMT_N*PH_W-1:0] DEF_PHASE_TBL =
        {16'hC000, 16'h4000, 16'h8000, 16'h0000};
endpackage

// File: rtl/stn_defaults.sv
module stn_defaults #(
    parameter int FREQ_W = stn_pkg::FREQ_W,
    parameter int PH_W   = stn_pkg::PH_W,
    parameter int FMT_N  = stn_pkg::FMT_N,
    parameter int FMT_W  = stn_pkg::FMT_W,
    parameter logic [FMT_N*FREQ_W-1:0] FREQ_TBL  = stn_pkg::DEF_FREQ_TBL,
    parameter logic [FMT_N*PH_W-1:0]   PHASE_TBL = stn_pkg::DEF_PHASE_TBL
) (
    input  logic [FMT_W-1:0]  fmt_sel,
    output logic [FREQ_W-1:0] def_freq,
    output logic [PH_W-1:0]   def_phase
);
    logic [FREQ_W-1:0] f_tab [FMT_N];
    logic [PH_W-1:0]   p_tab [FMT_N];

    for (genvar g = 0; g < FMT_N; g++) begin : g_tab
        assign f_tab[g] = FREQ_TBL[g*FREQ_W +: FREQ_W];
        assign p_tab[g] = PHASE_TBL[g*PH_W +: PH_W];
    end

    always_comb begin
        def_freq  = f_tab[0];
        def_phase = p_tab[0];
        for (int i = 0; i < FMT_N; i++) begin
            if (int'(fmt_sel) == i) begin
                def_freq  = f_tab[i];
                def_phase = p_tab[i];
            end
        end
    end
endmodule

// File: rtl/stn_nib_ser.sv
module stn_nib_ser #(
    parameter int PKT_W = 52,
    parameter int NIB_W = stn_pkg::NIB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             px_en,
    input  logic             tip_win,
    input  logic [PKT_W-1:0] pkt,
    output logic             nib_act,
    output logic [NIB_W-1:0] nib
);
    localparam int NIBS  = PKT_W / NIB_W;
    localparam int CNT_W = $clog2(NIBS + 1);

    typedef struct packed {
        logic             tip;
        logic [PKT_W-1:0] sh;
        logic [CNT_W-1:0] left;
    } ser_st_t;

    ser_st_t st_d, st_q;
    logic    start;

    always_comb begin
        st_d    = st_q;
        nib_act = 1'b0;
        nib     = '0;
        start   = tip_win && !st_q.tip;

        if (start) begin
            nib_act = 1'b1;
            nib     = pkt[PKT_W-1 -: NIB_W];
        end else if (tip_win && st_q.left != '0) begin
            nib_act = 1'b1;
            nib     = st_q.sh[PKT_W-1 -: NIB_W];
        end

        if (px_en) begin
            st_d.tip = tip_win;
            if (start) begin
                st_d.sh   = pkt << NIB_W;
                st_d.left = CNT_W'(NIBS - 1);
            end else if (nib_act) begin
                st_d.sh   = st_q.sh << NIB_W;
                st_d.left = st_q.left - 1'b1;
            end else if (!tip_win) begin
                st_d.left = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        px_en && tip_win && !st_q.tip |=> st_q.left == CNT_W'(NIBS - 1)); // R3
    AST_LEFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.left <= CNT_W'(NIBS - 1)); // R3
    AST_DROP_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        px_en && !tip_win |=> st_q.left == '0); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !px_en |=> $stable(st_q.left) && $stable(st_q.sh)); // R10
endmodule

// File: rtl/stn_bus_mux.sv
module stn_bus_mux #(
    parameter int BUS_W = stn_pkg::BUS_W,
    parameter int NIB_W = stn_pkg::NIB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             px_en,
    input  logic [BUS_W-1:0] smp,
    input  logic             nib_act,
    input  logic [NIB_W-1:0] nib,
    output logic [BUS_W-1:0] vout,
    output logic             vout_ld
);
    typedef struct packed {
        logic [BUS_W-1:0] bus;
        logic             ld;
    } mux_st_t;

    mux_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ld = px_en;
        if (px_en) begin
            st_d.bus = nib_act ? BUS_W'(nib) : smp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vout    = st_q.bus;
    assign vout_ld = st_q.ld;

    AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        px_en && nib_act |=> vout[BUS_W-1:NIB_W] == '0); // R4
    AST_PASS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        px_en && !nib_act |=> vout == $past(smp)); // R2
    AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !px_en |=> $stable(vout) && !vout_ld); // R10
endmodule

// File: rtl/sync_tip_inserter.sv
module sync_tip_inserter #(
    parameter int BUS_W  = stn_pkg::BUS_W,
    parameter int NIB_W  = stn_pkg::NIB_W,
    parameter int FREQ_W = stn_pkg::FREQ_W,
    parameter int PH_W   = stn_pkg::PH_W,
    parameter int FID_W  = stn_pkg::FID_W,
    parameter int FMT_N  = stn_pkg::FMT_N,
    parameter int FMT_W  = stn_pkg::FMT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              px_en,
    input  logic [BUS_W-1:0]  smp_in,
    input  logic              tip_win,
    input  logic              vid_ok,
    input  logic [FMT_W-1:0]  fmt_sel,
    input  logic [FREQ_W-1:0] trk_freq,
    input  logic [PH_W-1:0]   trk_phase,
    input  logic [FID_W-1:0]  trk_fid,
    output logic [BUS_W-1:0]  vout,
    output logic              vout_ld
);
    localparam int PKT_W = FREQ_W + PH_W + FID_W;

    logic [FREQ_W-1:0] def_freq;
    logic [PH_W-1:0]   def_phase;
    logic [PKT_W-1:0]  pkt;
    logic              nib_act;
    logic [NIB_W-1:0]  nib;

    stn_defaults #(
        .FREQ_W(FREQ_W), .PH_W(PH_W), .FMT_N(FMT_N), .FMT_W(FMT_W)
    ) u_defaults (
        .fmt_sel  (fmt_sel),
        .def_freq (def_freq),
        .def_phase(def_phase)
    );

    // R8 / R9: source picked here, captured by the serializer on the first tip tick
    assign pkt = vid_ok ? {trk_freq, trk_phase, trk_fid}
                        : {def_freq, def_phase, FID_W'(0)};

    stn_nib_ser #(.PKT_W(PKT_W), .NIB_W(NIB_W)) u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .px_en  (px_en),
        .tip_win(tip_win),
        .pkt    (pkt),
        .nib_act(nib_act),
        .nib    (nib)
    );

    stn_bus_mux #(.BUS_W(BUS_W), .NIB_W(NIB_W)) u_mux (
        .clk    (clk),
        .rst_n  (rst_n),
        .px_en  (px_en),
        .smp    (smp_in),
        .nib_act(nib_act),
        .nib    (nib),
        .vout   (vout),
        .vout_ld(vout_ld)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> vout == '0 && !vout_ld); // R1
endmodule

// File: tb/sync_tip_inserter_bench.sv
`timescale 1ns/1ps
module sync_tip_inserter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        px_en = 1'b0;
    logic [7:0]  smp_in = '0;
    logic        tip_win = 1'b0;
    logic        vid_ok = 1'b1;
    logic [1:0]  fmt_sel = '0;
    logic [31:0] trk_freq = 32'h12345678;
    logic [15:0] trk_phase = 16'h9ABC;
    logic [3:0]  trk_fid = 4'hD;
    logic [7:0]  vout;
    logic        vout_ld;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sync_tip_inserter u_sync_tip_inserter (
        .clk(clk), .rst_n(rst_n), .px_en(px_en), .smp_in(smp_in),
        .tip_win(tip_win), .vid_ok(vid_ok), .fmt_sel(fmt_sel),
        .trk_freq(trk_freq), .trk_phase(trk_phase), .trk_fid(trk_fid),
        .vout(vout), .vout_ld(vout_ld)
    );

    typedef struct packed {
        logic       tip;
        logic [7:0] smp;
        logic [7:0] exp;
    } vec_t;

    // tracked packet 12345678 / 9ABC / D gives nibbles 1..D in order (R3)
    localparam vec_t VECS [17] = '{
        '{1'b0, 8'h10, 8'h10}, '{1'b0, 8'h20, 8'h20},
        '{1'b1, 8'hAA, 8'h01}, '{1'b1, 8'hAA, 8'h02}, '{1'b1, 8'hAA, 8'h03},
        '{1'b1, 8'hAA, 8'h04}, '{1'b1, 8'hAA, 8'h05}, '{1'b1, 8'hAA, 8'h06},
        '{1'b1, 8'hAA, 8'h07}, '{1'b1, 8'hAA, 8'h08}, '{1'b1, 8'hAA, 8'h09},
        '{1'b1, 8'hAA, 8'h0A}, '{1'b1, 8'hAA, 8'h0B}, '{1'b1, 8'hAA, 8'h0C},
        '{1'b1, 8'hAA, 8'h0D}, '{1'b1, 8'h55, 8'h55}, '{1'b0, 8'h66, 8'h66}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one pixel tick: drive at negedge, capture at posedge, return at next negedge
    task automatic tick(input logic tip, input logic [7:0] smp);
        px_en   = 1'b1;
        tip_win = tip;
        smp_in  = smp;
        @(posedge clk);
        @(negedge clk);
        px_en = 1'b0;
    endtask

    task automatic run_line(input logic [51:0] p, input string tag);
        for (int i = 0; i < 13; i++) begin
            tick(1'b1, 8'hEE);
            chk(tag, vout, {4'h0, p[51-4*i -: 4]});
        end
        tick(1'b0, 8'h3C);
        chk({tag, " line end"}, vout, 8'h3C);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset vout", vout, 8'h00);
        chk("R1 reset ld", {7'b0, vout_ld}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk, one tick per vector (R2 R3 R4 R7)
        for (int k = 0; k < 17; k++) begin
            tick(VECS[k].tip, VECS[k].smp);
            chk("R2/R3/R4/R7 table vout", vout, VECS[k].exp);
            chk("R2 table ld", {7'b0, vout_ld}, 8'h01);
        end
        @(negedge clk);
        chk("R2 ld drops without tick", {7'b0, vout_ld}, 8'h00);

        // R10: gap mid packet
        tick(1'b1, 8'hEE);
        chk("R10 first nibble", vout, 8'h01);
        tip_win = 1'b1;
        smp_in  = 8'h99;
        for (int g = 0; g < 3; g++) begin
            @(negedge clk);
            chk("R10 gap vout holds", vout, 8'h01);
            chk("R10 gap ld low", {7'b0, vout_ld}, 8'h00);
        end
        tick(1'b1, 8'hEE);
        chk("R10 resumes at second nibble", vout, 8'h02);

        // R6: early close then restart
        tick(1'b0, 8'h77);
        chk("R6 close passes sample", vout, 8'h77);
        tick(1'b0, 8'h78);
        chk("R6 still sample", vout, 8'h78);
        tick(1'b1, 8'hEE);
        chk("R6 restart at first nibble", vout, 8'h01);

        // R5: words change after capture
        trk_freq  = 32'hFFFFFFFF;
        trk_phase = 16'h0000;
        trk_fid   = 4'h0;
        vid_ok    = 1'b0;
        for (int i = 1; i < 13; i++) begin
            tick(1'b1, 8'hEE);
            chk("R5 captured words", vout, 8'(i + 1));
        end
        tick(1'b0, 8'h41);
        chk("R5 line end", vout, 8'h41);

        // R8: defaults when video absent
        fmt_sel = 2'd1;
        run_line({32'h2A098ACB, 16'h8000, 4'h0}, "R8 fmt1 defaults");
        fmt_sel = 2'd3;
        run_line({32'h21E6EFE3, 16'hC000, 4'h0}, "R8 fmt3 defaults");

        // R9: tracked on first line after video returns
        vid_ok    = 1'b1;
        trk_freq  = 32'hA5C3_0F96;
        trk_phase = 16'h7E21;
        trk_fid   = 4'h6;
        run_line({32'hA5C30F96, 16'h7E21, 4'h6}, "R9 tracked after return");

        // R7: long tip after a full packet
        run_line({32'hA5C30F96, 16'h7E21, 4'h6}, "R9 second line");
        tick(1'b1, 8'hEE);
        for (int i = 1; i < 13; i++) tick(1'b1, 8'hEE);
        tick(1'b1, 8'hB4);
        chk("R7 sample after packet", vout, 8'hB4);
        tick(1'b1, 8'hB5);
        chk("R7 sample after packet 2", vout, 8'hB5);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule